// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block owns the current status word and the five banked saved-status words of a small 32-bit core, and it decides, cycle by cycle, whether the pipeline is redirected into an exception handler or back out of one. The pipeline presents fault strobes, a reset request, two external interrupt levels, the current PC and a return request. From these the block picks at most one event per cycle. It then produces a registered PC redirect, a link-register write tagged with the mode whose link register receives it, and a saved-status write tagged with the same mode.

On entry, the old status word goes into the target mode's saved register. The new status word takes the target mode code and has the normal-interrupt mask set. The fast-interrupt mask is set only for a fast interrupt or a reset request. On return, the saved word of the active mode and the new PC take effect at the same clock edge. The datapath keeps the banked link registers, so the return address comes in on a port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_n is low, and after it rises with no other request, status_word is 0x000000D3 (mode field bits [4:0] = 10011 supervisor, normal-interrupt mask bit 7 = 1, fast-interrupt mask bit 6 = 1), all write and load strobes are low, and every saved-status register holds 0x00000010.
- R2: Each cause redirects to VEC_BASE plus its offset and uses its own mode code: undefined instruction 0x04 / 11011, service call 0x08 / 10011, fetch abort 0x0C / 10111, data abort 0x10 / 10111, normal interrupt 0x18 / 10010, fast interrupt 0x1C / 10001.
- R3: A non-reset entry writes the status word from before the entry into the target mode's saved register (saved_we=1, saved_mode = target mode code, saved_data = old status word).
- R4: On entry the mode field takes the target mode, bit 7 is set, bit 6 is set only for a fast interrupt, and all other bits keep their values.
- R5: A non-reset entry writes cur_pc - 4 (LINK_OFFSET) to the link register of the target mode (link_we=1, link_mode = target mode code).
- R6: When several causes are present at once, the one taken is the first of: reset request, data abort, fast interrupt, normal interrupt, fetch abort, undefined instruction, service call.
- R7: norm_irq has no effect while bit 7 is set, and fast_irq has no effect while bit 6 is set.
- R8: A return while in a banked mode loads pc_target = ret_link and restores status_word from that mode's saved register at the same edge.
- R9: A return with ret_alt=1 loads pc_target = ret_link - 4 (RET_ADJUST).
- R10: A return request has no effect in user (10000) or system (11111) mode, and none when an exception is taken in the same cycle.
- R11: A reset request redirects to VEC_BASE with status_word 0x000000D3 and writes neither a link register nor a saved register.
- R12: All outputs change at the clock edge that samples the request, and the strobes last exactly one cycle unless the next cycle also takes an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_req | input | 1 | Reset exception request |
| undef_stb | input | 1 | Undefined-instruction strobe |
| svc_call_stb | input | 1 | Service-call instruction strobe |
| fetch_abort_stb | input | 1 | Instruction-fetch abort strobe |
| data_abort_stb | input | 1 | Data-access abort strobe |
| norm_irq | input | 1 | Normal external interrupt level |
| fast_irq | input | 1 | Fast external interrupt level |
| cur_pc | input | ADDR_W | PC of the faulting or interrupted instruction |
| ret_req | input | 1 | Return-from-exception request |
| ret_alt | input | 1 | Return form that subtracts RET_ADJUST |
| ret_link | input | ADDR_W | Link register value of the active mode |
| pc_load | output | 1 | Redirect strobe |
| pc_target | output | ADDR_W | New PC |
| link_we | output | 1 | Link register write strobe |
| link_mode | output | 5 | Mode whose link register is written |
| link_data | output | ADDR_W | Return address to store |
| saved_we | output | 1 | Saved-status write strobe |
| saved_mode | output | 5 | Mode whose saved register is written |
| saved_data | output | 32 | Status word being saved |
| status_word | output | 32 | Current status word |

## Verification
A wrong saved-status bank shows up only at the next return, when status_word takes a value other than the one saved on entry. The bench therefore pairs every entry with a return and checks the restored word in the cycle after that return is sampled. A wrong mask or priority decision shows one cycle after the request: pc_target, link_mode or status_word is wrong, or pc_load is missing or unexpected. Nested entries from interrupt mode into fast-interrupt mode, followed by two returns, catch a saved register written into the wrong bank.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the exception entry controller.
// Assumes a 32-bit status word with the mode in bits [4:0], the
// fast-interrupt mask in bit 6 and the normal-interrupt mask in bit 7.
package exc_pkg;

    localparam int ST_W      = 32;
    localparam int MODE_W    = 5;
    localparam int ST_F_BIT  = 6;
    localparam int ST_I_BIT  = 7;
    localparam int NUM_BANKS = 5;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    localparam logic [MODE_W-1:0] MODE_USER   = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FAST   = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_NORM   = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SUPV   = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABORT  = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UNDEF  = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYSTEM = 5'b11111;

    localparam logic [ST_W-1:0] ST_RESET      = 32'h0000_00D3;
    localparam logic [ST_W-1:0] ST_SAVED_INIT = 32'h0000_0010;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_RESET,
        CAUSE_UNDEF,
        CAUSE_SVC,
        CAUSE_FETCH_ABT,
        CAUSE_DATA_ABT,
        CAUSE_NORM_IRQ,
        CAUSE_FAST_IRQ
    } cause_e;

    // Word index of the handler entry inside the vector region.
    function automatic logic [2:0] vector_slot(cause_e c);
        case (c)
            CAUSE_UNDEF:     return 3'd1;
            CAUSE_SVC:       return 3'd2;
            CAUSE_FETCH_ABT: return 3'd3;
            CAUSE_DATA_ABT:  return 3'd4;
            CAUSE_NORM_IRQ:  return 3'd6;
            CAUSE_FAST_IRQ:  return 3'd7;
            default:         return 3'd0;
        endcase
    endfunction

    // Mode code entered for each cause.
    function automatic logic [MODE_W-1:0] target_mode(cause_e c);
        case (c)
            CAUSE_UNDEF:     return MODE_UNDEF;
            CAUSE_FETCH_ABT: return MODE_ABORT;
            CAUSE_DATA_ABT:  return MODE_ABORT;
            CAUSE_NORM_IRQ:  return MODE_NORM;
            CAUSE_FAST_IRQ:  return MODE_FAST;
            default:         return MODE_SUPV;
        endcase
    endfunction

    // Saved-register bank index for a mode code.
    function automatic logic [BANK_W-1:0] bank_of(logic [MODE_W-1:0] m);
        case (m)
            MODE_FAST:  return BANK_W'(0);
            MODE_NORM:  return BANK_W'(1);
            MODE_SUPV:  return BANK_W'(2);
            MODE_ABORT: return BANK_W'(3);
            MODE_UNDEF: return BANK_W'(4);
            default:    return BANK_W'(0);
        endcase
    endfunction

    // True when the mode owns a saved-status register.
    function automatic logic has_bank(logic [MODE_W-1:0] m);
        case (m)
            MODE_USER, MODE_SYSTEM: return 1'b0;
            MODE_FAST, MODE_NORM, MODE_SUPV,
            MODE_ABORT, MODE_UNDEF: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
// Module: exc_arbiter
// Masks the interrupt levels with the current status bits and picks the
// single cause to take this cycle by fixed priority.
// Assumes strobes are already aligned to the controller clock.
module exc_arbiter
    import exc_pkg::*;
(
    input  logic   reset_req,
    input  logic   data_abort_stb,
    input  logic   fast_irq,
    input  logic   norm_irq,
    input  logic   fetch_abort_stb,
    input  logic   undef_stb,
    input  logic   svc_call_stb,
    input  logic   i_mask,
    input  logic   f_mask,
    output cause_e cause
);

    localparam int NUM_REQ = 7;

    logic [NUM_REQ-1:0] req;

    // Cause held by each request bit; bit 0 has the highest priority.
    function automatic cause_e cause_at(int k);
        case (k)
            0:       return CAUSE_RESET;
            1:       return CAUSE_DATA_ABT;
            2:       return CAUSE_FAST_IRQ;
            3:       return CAUSE_NORM_IRQ;
            4:       return CAUSE_FETCH_ABT;
            5:       return CAUSE_UNDEF;
            default: return CAUSE_SVC;
        endcase
    endfunction

    // Gather requests in priority order, interrupts behind their masks.
    always_comb begin
        req[0] = reset_req;
        req[1] = data_abort_stb;
        req[2] = fast_irq & ~f_mask;
        req[3] = norm_irq & ~i_mask;
        req[4] = fetch_abort_stb;
        req[5] = undef_stb;
        req[6] = svc_call_stb;
    end

    // Lowest set bit wins.
    always_comb begin
        cause = CAUSE_NONE;
        for (int k = NUM_REQ - 1; k >= 0; k--) begin
            if (req[k]) cause = cause_at(k);
        end
    end

endmodule

// File: rtl/exc_status_bank.sv
`timescale 1ns/1ps
// Module: exc_status_bank
// Holds the current status word and one saved-status register per
// exception mode. A write port per register class, one read port for
// the saved bank. Assumes saved_idx and rd_idx are below N.
module exc_status_bank
    import exc_pkg::*;
#(
    parameter int              N         = NUM_BANKS,
    parameter logic [ST_W-1:0] RST_ST    = ST_RESET,
    parameter logic [ST_W-1:0] SAVED_RST = ST_SAVED_INIT,
    localparam int             IDX_W     = (N > 1) ? $clog2(N) : 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             status_we,
    input  logic [ST_W-1:0]  status_d,
    input  logic             saved_we,
    input  logic [IDX_W-1:0] saved_idx,
    input  logic [ST_W-1:0]  saved_d,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ST_W-1:0]  status_q,
    output logic [ST_W-1:0]  saved_rd
);

    logic [ST_W-1:0] saved_all [N];

    // Current status word register.
    always_ff @(posedge clk) begin
        if (!rst_n)         status_q <= RST_ST;
        else if (status_we) status_q <= status_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_bank
        logic [ST_W-1:0] q;

        // Saved-status register of one mode.
        always_ff @(posedge clk) begin
            if (!rst_n)                                      q <= SAVED_RST;
            else if (saved_we && saved_idx == IDX_W'(g))     q <= saved_d;
        end

        assign saved_all[g] = q;
    end

    // Read port selecting the active mode's saved word.
    always_comb begin
        saved_rd = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_idx == IDX_W'(k)) saved_rd = saved_all[k];
        end
    end

endmodule

// File: rtl/exc_vector_gen.sv
`timescale 1ns/1ps
// Module: exc_vector_gen
// Pure logic: for the chosen cause, forms the handler address, the
// target mode, the status word after entry and the return address.
// Assumes the vector region starts at VEC_BASE with one word per cause.
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE    = '0,
    parameter logic [ADDR_W-1:0] LINK_OFFSET = ADDR_W'(4)
)(
    input  cause_e              cause,
    input  logic [ADDR_W-1:0]   cur_pc,
    input  logic [ST_W-1:0]     status_q,
    output logic [ADDR_W-1:0]   vec_addr,
    output logic [MODE_W-1:0]   tgt_mode,
    output logic [ST_W-1:0]     entry_status,
    output logic [ADDR_W-1:0]   link_value,
    output logic                writes_link
);

    // Handler address and return address.
    always_comb begin
        vec_addr    = VEC_BASE + ADDR_W'({vector_slot(cause), 2'b00});
        link_value  = cur_pc - LINK_OFFSET;
        tgt_mode    = target_mode(cause);
        writes_link = (cause != CAUSE_NONE) && (cause != CAUSE_RESET);
    end

    // Status word after entry: mode replaced, masks raised.
    always_comb begin
        if (cause == CAUSE_RESET) begin
            entry_status = ST_RESET;
        end else begin
            entry_status               = status_q;
            entry_status[MODE_W-1:0]   = tgt_mode;
            entry_status[ST_I_BIT]     = 1'b1;
            if (cause == CAUSE_FAST_IRQ) entry_status[ST_F_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
// Module: exc_entry_ctrl (top)
// Sequences exception entry and return: arbitrates causes, updates the
// status word and the banked saved registers, and issues registered PC,
// link-register and saved-status writes one cycle after the request.
// Assumes link registers live in the datapath and ret_link carries the
// active mode's value.
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE    = '0,
    parameter logic [ADDR_W-1:0] LINK_OFFSET = ADDR_W'(4),
    parameter logic [ADDR_W-1:0] RET_ADJUST  = ADDR_W'(4)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              undef_stb,
    input  logic              svc_call_stb,
    input  logic              fetch_abort_stb,
    input  logic              data_abort_stb,
    input  logic              norm_irq,
    input  logic              fast_irq,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic              ret_req,
    input  logic              ret_alt,
    input  logic [ADDR_W-1:0] ret_link,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_target,
    output logic              link_we,
    output logic [4:0]        link_mode,
    output logic [ADDR_W-1:0] link_data,
    output logic              saved_we,
    output logic [4:0]        saved_mode,
    output logic [31:0]       saved_data,
    output logic [31:0]       status_word
);

    cause_e             cause;
    logic [ADDR_W-1:0]  vec_addr;
    logic [MODE_W-1:0]  tgt_mode;
    logic [ST_W-1:0]    entry_status;
    logic [ADDR_W-1:0]  link_value;
    logic               writes_link;
    logic [ST_W-1:0]    saved_rd;
    logic               exc_take;
    logic               ret_take;
    logic               st_we;
    logic [ST_W-1:0]    st_d;
    logic               sv_we;
    logic [ADDR_W-1:0]  ret_pc;

    exc_arbiter i_arb (
        .reset_req       (reset_req),
        .data_abort_stb  (data_abort_stb),
        .fast_irq        (fast_irq),
        .norm_irq        (norm_irq),
        .fetch_abort_stb (fetch_abort_stb),
        .undef_stb       (undef_stb),
        .svc_call_stb    (svc_call_stb),
        .i_mask          (status_word[ST_I_BIT]),
        .f_mask          (status_word[ST_F_BIT]),
        .cause           (cause)
    );

    exc_vector_gen #(
        .ADDR_W      (ADDR_W),
        .VEC_BASE    (VEC_BASE),
        .LINK_OFFSET (LINK_OFFSET)
    ) i_vec (
        .cause        (cause),
        .cur_pc       (cur_pc),
        .status_q     (status_word),
        .vec_addr     (vec_addr),
        .tgt_mode     (tgt_mode),
        .entry_status (entry_status),
        .link_value   (link_value),
        .writes_link  (writes_link)
    );

    // Decide between entry, return or nothing, and form write data.
    always_comb begin
        exc_take = (cause != CAUSE_NONE);
        ret_take = ret_req && !exc_take && has_bank(status_word[MODE_W-1:0]);
        st_we    = exc_take || ret_take;
        st_d     = exc_take ? entry_status : saved_rd;
        sv_we    = writes_link;
        ret_pc   = ret_alt ? (ret_link - RET_ADJUST) : ret_link;
    end

    exc_status_bank #(
        .N         (NUM_BANKS),
        .RST_ST    (ST_RESET),
        .SAVED_RST (ST_SAVED_INIT)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_we (st_we),
        .status_d  (st_d),
        .saved_we  (sv_we),
        .saved_idx (bank_of(tgt_mode)),
        .saved_d   (status_word),
        .rd_idx    (bank_of(status_word[MODE_W-1:0])),
        .status_q  (status_word),
        .saved_rd  (saved_rd)
    );

    // Registered redirect, link and saved-status write outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_load    <= 1'b0;
            pc_target  <= '0;
            link_we    <= 1'b0;
            link_mode  <= '0;
            link_data  <= '0;
            saved_we   <= 1'b0;
            saved_mode <= '0;
            saved_data <= '0;
        end else begin
            pc_load    <= st_we;
            pc_target  <= exc_take ? vec_addr : (ret_take ? ret_pc : '0);
            link_we    <= writes_link;
            link_mode  <= writes_link ? tgt_mode : '0;
            link_data  <= writes_link ? link_value : '0;
            saved_we   <= sv_we;
            saved_mode <= sv_we ? tgt_mode : '0;
            saved_data <= sv_we ? status_word : '0;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
`timescale 1ns/1ps
// Module: exc_entry_ctrl_chk
// Property checker bound onto exc_entry_ctrl; observes ports only.
module exc_entry_ctrl_chk
    import exc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reset_req,
    input logic        undef_stb,
    input logic        svc_call_stb,
    input logic        fetch_abort_stb,
    input logic        data_abort_stb,
    input logic        norm_irq,
    input logic        fast_irq,
    input logic        ret_req,
    input logic        pc_load,
    input logic        link_we,
    input logic [4:0]  link_mode,
    input logic        saved_we,
    input logic [4:0]  saved_mode,
    input logic [31:0] saved_data,
    input logic [31:0] status_word
);

    logic past_ok;

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    logic no_strobe;
    assign no_strobe = !reset_req && !undef_stb && !svc_call_stb &&
                       !fetch_abort_stb && !data_abort_stb;

    a_r11_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(reset_req) |->
            pc_load && !link_we && !saved_we && status_word == ST_RESET);

    a_r3_saved_copy: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && saved_we |-> saved_data == $past(status_word));

    a_r4_norm_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        saved_we |-> status_word[ST_I_BIT]);

    a_r4_fast_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && saved_we && saved_mode != MODE_FAST |->
            status_word[ST_F_BIT] == $past(status_word[ST_F_BIT]));

    a_r5_link_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> saved_we && pc_load && link_mode == saved_mode);

    a_r6_data_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(data_abort_stb && !reset_req) |-> link_mode == MODE_ABORT);

    a_r7_masked_norm: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(norm_irq && status_word[ST_I_BIT] && !fast_irq &&
                         no_strobe && !ret_req) |->
            !pc_load && $stable(status_word));

    a_r10_user_return: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(ret_req && status_word[4:0] == MODE_USER && no_strobe &&
                         !norm_irq && !fast_irq) |-> !pc_load);

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reset_req       (reset_req),
    .undef_stb       (undef_stb),
    .svc_call_stb    (svc_call_stb),
    .fetch_abort_stb (fetch_abort_stb),
    .data_abort_stb  (data_abort_stb),
    .norm_irq        (norm_irq),
    .fast_irq        (fast_irq),
    .ret_req         (ret_req),
    .pc_load         (pc_load),
    .link_we         (link_we),
    .link_mode       (link_mode),
    .saved_we        (saved_we),
    .saved_mode      (saved_mode),
    .saved_data      (saved_data),
    .status_word     (status_word)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
// Bench for exc_entry_ctrl: table of single entries each followed by a
// return, then directed tests for masking, nesting, returns and reset.
module test_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reset_req = 0, undef_stb = 0, svc_call_stb = 0;
    logic        fetch_abort_stb = 0, data_abort_stb = 0;
    logic        norm_irq = 0, fast_irq = 0;
    logic [31:0] cur_pc = '0;
    logic        ret_req = 0, ret_alt = 0;
    logic [31:0] ret_link = '0;
    logic        pc_load, link_we, saved_we;
    logic [31:0] pc_target, link_data, saved_data, status_word;
    logic [4:0]  link_mode, saved_mode;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .undef_stb(undef_stb),
        .svc_call_stb(svc_call_stb), .fetch_abort_stb(fetch_abort_stb),
        .data_abort_stb(data_abort_stb), .norm_irq(norm_irq), .fast_irq(fast_irq),
        .cur_pc(cur_pc), .ret_req(ret_req), .ret_alt(ret_alt), .ret_link(ret_link),
        .pc_load(pc_load), .pc_target(pc_target), .link_we(link_we),
        .link_mode(link_mode), .link_data(link_data), .saved_we(saved_we),
        .saved_mode(saved_mode), .saved_data(saved_data), .status_word(status_word)
    );

    // Request bits: {reset, data abort, fast, normal, fetch abort, undef, svc}
    // Row: {req[6:0], vector[7:0], status low byte[7:0], mode[4:0]}
    localparam int NROW = 11;
    localparam logic [27:0] TBL [NROW] = '{
        {7'b0000010, 8'h04, 8'h9B, 5'b11011},
        {7'b0000001, 8'h08, 8'h93, 5'b10011},
        {7'b0000100, 8'h0C, 8'h97, 5'b10111},
        {7'b0100000, 8'h10, 8'h97, 5'b10111},
        {7'b0001000, 8'h18, 8'h92, 5'b10010},
        {7'b0010000, 8'h1C, 8'hD1, 5'b10001},
        {7'b0111111, 8'h10, 8'h97, 5'b10111},
        {7'b0011100, 8'h1C, 8'hD1, 5'b10001},
        {7'b0001110, 8'h18, 8'h92, 5'b10010},
        {7'b0000111, 8'h0C, 8'h97, 5'b10111},
        {7'b0000011, 8'h04, 8'h9B, 5'b11011}
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus; outputs are valid on return.
    task automatic apply(input logic [6:0] req, input logic [31:0] pc,
                         input logic ret, input logic alt, input logic [31:0] lnk);
        @(negedge clk);
        {reset_req, data_abort_stb, fast_irq, norm_irq,
         fetch_abort_stb, undef_stb, svc_call_stb} = req;
        cur_pc = pc; ret_req = ret; ret_alt = alt; ret_link = lnk;
        @(posedge clk);
        #1;
        {reset_req, data_abort_stb, fast_irq, norm_irq,
         fetch_abort_stb, undef_stb, svc_call_stb} = '0;
        ret_req = 0; ret_alt = 0;
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "status in reset", status_word, 32'h0000_00D3);
        chk("R1", "pc_load in reset", {31'b0, pc_load}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "status after reset", status_word, 32'h0000_00D3);
        chk("R1", "saved_we after reset", {31'b0, saved_we}, 32'h0);

        // Return from supervisor: saved word starts as user mode (R1, R8).
        apply(7'b0, 32'h0, 1'b1, 1'b0, 32'h0000_0400);
        chk("R8", "return pc", pc_target, 32'h0000_0400);
        chk("R1", "initial saved word restored", status_word, 32'h0000_0010);

        // Table of entries from user mode, each undone by a return.
        for (int i = 0; i < NROW; i++) begin
            logic [6:0]  rq;
            logic [31:0] pc, lnk, exp_pc;
            logic        alt;
            rq  = TBL[i][27:21];
            pc  = 32'h1000 + 32'(i) * 32'h10;
            lnk = 32'h2000 + 32'(i) * 32'h8;
            alt = i[0];
            apply(rq, pc, 1'b0, 1'b0, '0);
            chk("R2", "pc_load", {31'b0, pc_load}, 32'h1);
            chk("R2 R6", "vector", pc_target, {24'h0, TBL[i][20:13]});
            chk("R4", "status after entry", status_word, {24'h0, TBL[i][12:5]});
            chk("R5", "link_we", {31'b0, link_we}, 32'h1);
            chk("R5 R6", "link_mode", {27'b0, link_mode}, {27'b0, TBL[i][4:0]});
            chk("R5", "link_data", link_data, pc - 32'h4);
            chk("R3", "saved_mode", {27'b0, saved_mode}, {27'b0, TBL[i][4:0]});
            chk("R3", "saved_data", saved_data, 32'h0000_0010);
            apply(7'b0, 32'h0, 1'b1, alt, lnk);
            exp_pc = alt ? lnk - 32'h4 : lnk;
            chk(alt ? "R9" : "R8", "return pc", pc_target, exp_pc);
            chk("R8", "status restored", status_word, 32'h0000_0010);
            chk("R8", "no saved write on return", {31'b0, saved_we}, 32'h0);
        end

        // One-cycle strobes (R12).
        apply(7'b0000010, 32'h3000, 1'b0, 1'b0, '0);
        @(posedge clk); #1;
        chk("R12", "pc_load drops", {31'b0, pc_load}, 32'h0);
        chk("R12", "link_we drops", {31'b0, link_we}, 32'h0);
        apply(7'b0, 32'h0, 1'b1, 1'b0, 32'h3000);
        chk("R8", "back to user", status_word, 32'h0000_0010);

        // Masking and nesting (R7, R3, R4).
        apply(7'b0001000, 32'h4000, 1'b0, 1'b0, '0);
        chk("R4", "normal entry", status_word, 32'h0000_0092);
        apply(7'b0001000, 32'h4100, 1'b0, 1'b0, '0);
        chk("R7", "masked normal no load", {31'b0, pc_load}, 32'h0);
        chk("R7", "masked normal status", status_word, 32'h0000_0092);
        apply(7'b0010000, 32'h4200, 1'b0, 1'b0, '0);
        chk("R7", "fast taken in normal mode", pc_target, 32'h0000_001C);
        chk("R4", "fast entry status", status_word, 32'h0000_00D1);
        chk("R3", "nested saved_data", saved_data, 32'h0000_0092);
        apply(7'b0010000, 32'h4300, 1'b0, 1'b0, '0);
        chk("R7", "masked fast no load", {31'b0, pc_load}, 32'h0);
        apply(7'b0001000, 32'h4300, 1'b0, 1'b0, '0);
        chk("R7", "masked normal in fast", status_word, 32'h0000_00D1);
        apply(7'b0, 32'h0, 1'b1, 1'b1, 32'h4204);
        chk("R9", "alt return pc", pc_target, 32'h0000_4200);
        chk("R8", "back to normal mode", status_word, 32'h0000_0092);
        apply(7'b0, 32'h0, 1'b1, 1'b0, 32'h4000);
        chk("R8", "back to user", status_word, 32'h0000_0010);

        // Return in user mode is ignored (R10).
        apply(7'b0, 32'h0, 1'b1, 1'b0, 32'h5000);
        chk("R10", "user return no load", {31'b0, pc_load}, 32'h0);
        chk("R10", "user return status", status_word, 32'h0000_0010);

        // Return with a same-cycle exception: exception wins (R10).
        apply(7'b0001000, 32'h6000, 1'b0, 1'b0, '0);
        apply(7'b0000010, 32'h6100, 1'b1, 1'b0, 32'h6000);
        chk("R10", "exception beats return", pc_target, 32'h0000_0004);
        chk("R10", "undef status", status_word, 32'h0000_009B);
        chk("R3", "saved from normal mode", saved_data, 32'h0000_0092);
        apply(7'b0, 32'h0, 1'b1, 1'b0, 32'h6100);
        chk("R8", "undef return", status_word, 32'h0000_0092);
        apply(7'b0, 32'h0, 1'b1, 1'b0, 32'h6000);
        chk("R8", "normal return", status_word, 32'h0000_0010);

        // Reset request beats everything (R11, R6).
        apply(7'b1100010, 32'h7000, 1'b1, 1'b0, 32'h7000);
        chk("R11", "reset vector", pc_target, 32'h0000_0000);
        chk("R11", "reset status", status_word, 32'h0000_00D3);
        chk("R11", "no link write", {31'b0, link_we}, 32'h0);
        chk("R11", "no saved write", {31'b0, saved_we}, 32'h0);
        apply(7'b0, 32'h0, 1'b1, 1'b0, 32'h7100);
        chk("R11", "supervisor saved word untouched", status_word, 32'h0000_0010);

        // Hardware reset mid-run (R1).
        apply(7'b0001000, 32'h8000, 1'b0, 1'b0, '0);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", "status after rst_n", status_word, 32'h0000_00D3);
        chk("R1", "pc_load after rst_n", {31'b0, pc_load}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        apply(7'b0, 32'h0, 1'b1, 1'b0, 32'h9000);
        chk("R1", "saved word reinitialised", status_word, 32'h0000_0010);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule